// File: doc/BRIEF.md
# Edge Interval Bit Checker

This block decides whether a demodulated data stream has plausible bit timing before a receiver acts on it. After an enable, it first waits a programmable start-up time, during which the demodulator output is not yet meaningful and is ignored. It then measures the time between successive transitions of the demodulator output. Time is counted in ticks of a reference clock enable, so the timing resolution is one tick.

Each measured interval is compared with a window built from a lower and an upper limit. A transition that comes too early fails the check. If the count reaches the upper limit before any transition arrives, the check also fails. After a programmable number of accepted intervals in a row, the block issues a pass pulse and moves to a receive state. A failure issues a fail pulse and drops the block back to sleep. It stays there until the enable is raised again.

Top module: `edge_window_checker`

## Requirements
- R1: After reset, `state_o` reads 0 (sleep), and `pass_pulse` and `fail_pulse` are low.
- R2: A rising edge on `enable` moves the block from sleep (0) to start-up (1). After `startup_len` ticks it moves to check (2). Any demodulator activity during start-up causes neither a pass nor a fail.
- R3: While `enable` is low, the block is in sleep (0), whatever state it was in. Dropping `enable` gives no pulse.
- R4: `demod_in` passes through a two-flop synchroniser. Both rising and falling transitions count as edges.
- R5: The interval counter advances by one only on cycles where `tick` is high, and only in check. The measured interval is therefore a number of ticks, not clock cycles.
- R6: The first edge seen in check only starts the first interval and is not compared against the window.
- R7: An edge whose interval is at least the effective lower limit and below `lim_hi` is accepted, and the counter restarts.
- R8: An edge whose interval is below the effective lower limit gives a one-cycle `fail_pulse` and a return to sleep (0).
- R9: When the count reaches `lim_hi`, the check fails at once with no edge needed. An edge arriving at exactly `lim_hi` ticks is therefore a failure.
- R10: A `lim_lo` value below 10 is treated as 10.
- R11: After `pass_need` consecutive accepted intervals, the block gives a one-cycle `pass_pulse` and enters receive (3). A `pass_need` of 0 behaves as 1. Edges arriving in receive cause no further pulse.
- R12: After a failure the block stays in sleep, even with `enable` still high, until `enable` is lowered and raised again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Block enable; a rising edge starts a check |
| tick | input | 1 | Reference clock enable, one pulse per time unit |
| demod_in | input | 1 | Asynchronous demodulator output |
| lim_lo | input | 6 | Shortest accepted interval in ticks (at least 10) |
| lim_hi | input | 6 | Count at which the check fails; longest accepted interval is one less |
| startup_len | input | 8 | Start-up length in ticks |
| pass_need | input | 4 | Accepted intervals in a row needed to pass |
| state_o | output | 2 | 0 sleep, 1 start-up, 2 check, 3 receive |
| pass_pulse | output | 1 | One-cycle pulse when the check passes |
| fail_pulse | output | 1 | One-cycle pulse when the check fails |

## Verification
The hardest cases to reach are the boundaries of the window, where one tick separates acceptance from failure. The hardest of these is an edge that lands on exactly the upper-limit count, where the timeout and the edge arrive in the same cycle. The stimulus reaches these cases by waiting until the design reports the check state and then arming it with a first transition. After that, the bench spaces all further transitions a fixed number of cycles apart. The synchroniser delay is the same for every transition, so the design measures exactly that spacing. A second set of runs gates `tick` to every other cycle, which shows that the window is counted in ticks and not in clock cycles.

// File: rtl/ewc_pkg.sv
package ewc_pkg;
  typedef enum logic [1:0] {
    ST_SLEEP   = 2'd0,
    ST_STARTUP = 2'd1,
    ST_CHECK   = 2'd2,
    ST_RECEIVE = 2'd3
  } ewc_state_e;
endpackage

// File: rtl/ewc_edge_sync.sv
module ewc_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic edge_o
);
  // chain[STAGES-1] is the synchronised sample, chain[STAGES] the previous one
  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-1:0], din};
  end

  // both polarities (R4)
  assign edge_o = chain[STAGES] ^ chain[STAGES-1];
endmodule

// File: rtl/ewc_interval_counter.sv
module ewc_interval_counter #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic         restart,
  input  logic         tick,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst || !run)            cnt <= '0;
    else if (restart)           cnt <= tick ? W'(1) : '0;
    else if (tick && cnt != '1) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/ewc_ctrl.sv
module ewc_ctrl
  import ewc_pkg::*;
#(
  parameter int LIM_W    = 6,
  parameter int SU_W     = 8,
  parameter int NEED_W   = 4,
  parameter int LO_FLOOR = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              tick,
  input  logic              edge_i,
  input  logic [LIM_W-1:0]  cnt,
  input  logic [LIM_W-1:0]  lim_lo,
  input  logic [LIM_W-1:0]  lim_hi,
  input  logic [SU_W-1:0]   startup_len,
  input  logic [NEED_W-1:0] pass_need,
  output logic [1:0]        state_o,
  output logic              pass_pulse,
  output logic              fail_pulse,
  output logic              cnt_run,
  output logic              cnt_restart
);
  localparam logic [LIM_W-1:0] LO_MIN = LIM_W'(LO_FLOOR);

  ewc_state_e        state;
  logic              en_q;
  logic              armed;
  logic [SU_W-1:0]   su_cnt;
  logic [NEED_W-1:0] ok_cnt;

  logic [LIM_W-1:0]  lo_eff;
  logic [NEED_W-1:0] need_eff;
  logic [NEED_W:0]   ok_next;
  logic [SU_W:0]     su_next;
  logic in_chk, too_long, measured, too_short, good, done, fail_now, leave;

  always_comb begin
    lo_eff    = (lim_lo < LO_MIN) ? LO_MIN : lim_lo;               // R10
    need_eff  = (pass_need == '0) ? NEED_W'(1) : pass_need;        // R11
    ok_next   = {1'b0, ok_cnt} + 1'b1;
    su_next   = {1'b0, su_cnt} + 1'b1;
    in_chk    = (state == ST_CHECK);
    too_long  = in_chk && (cnt >= lim_hi);                         // R9
    measured  = in_chk && edge_i && armed && !too_long;            // R6
    too_short = measured && (cnt < lo_eff);                        // R8
    good      = measured && !too_short;                            // R7
    done      = good && (ok_next >= {1'b0, need_eff});
    fail_now  = too_long || too_short;
    leave     = fail_now || done || !enable;
    cnt_run     = in_chk && !leave;
    cnt_restart = in_chk && edge_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_SLEEP;
      en_q       <= 1'b0;
      armed      <= 1'b0;
      su_cnt     <= '0;
      ok_cnt     <= '0;
      pass_pulse <= 1'b0;
      fail_pulse <= 1'b0;
    end else begin
      en_q       <= enable;
      pass_pulse <= 1'b0;
      fail_pulse <= 1'b0;
      if (!enable) begin
        state <= ST_SLEEP;                                          // R3
      end else begin
        unique case (state)
          ST_SLEEP: if (!en_q) begin                                // R12
            state  <= ST_STARTUP;
            su_cnt <= '0;
          end
          ST_STARTUP: if (tick) begin                               // R2
            if (su_next >= {1'b0, startup_len}) begin
              state  <= ST_CHECK;
              armed  <= 1'b0;
              ok_cnt <= '0;
            end else begin
              su_cnt <= su_next[SU_W-1:0];
            end
          end
          ST_CHECK: begin
            if (fail_now) begin
              fail_pulse <= 1'b1;
              state      <= ST_SLEEP;
            end else if (done) begin
              pass_pulse <= 1'b1;
              state      <= ST_RECEIVE;
            end else if (edge_i) begin
              armed <= 1'b1;
              if (good) ok_cnt <= ok_next[NEED_W-1:0];
            end
          end
          default: state <= ST_RECEIVE;
        endcase
      end
    end
  end

  assign state_o = state;

  assert_cnt_idle_R5: assert property (@(posedge clk) disable iff (rst)
    (state != ST_CHECK) |-> (cnt == '0));
  assert_fail_sleep_R8: assert property (@(posedge clk) disable iff (rst)
    fail_pulse |-> (state == ST_SLEEP));
  assert_pass_recv_R11: assert property (@(posedge clk) disable iff (rst)
    pass_pulse |-> (state == ST_RECEIVE));
  assert_one_outcome_R9: assert property (@(posedge clk) disable iff (rst)
    !(pass_pulse && fail_pulse));
  assert_enable_low_R3: assert property (@(posedge clk) disable iff (rst)
    !$past(enable) |-> (state == ST_SLEEP));
endmodule

// File: rtl/edge_window_checker.sv
module edge_window_checker #(
  parameter int LIM_W       = 6,
  parameter int SU_W        = 8,
  parameter int NEED_W      = 4,
  parameter int SYNC_STAGES = 2,
  parameter int LO_FLOOR    = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              tick,
  input  logic              demod_in,
  input  logic [LIM_W-1:0]  lim_lo,
  input  logic [LIM_W-1:0]  lim_hi,
  input  logic [SU_W-1:0]   startup_len,
  input  logic [NEED_W-1:0] pass_need,
  output logic [1:0]        state_o,
  output logic              pass_pulse,
  output logic              fail_pulse
);
  logic             edge_s;
  logic             cnt_run;
  logic             cnt_restart;
  logic [LIM_W-1:0] cnt;

  ewc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(demod_in), .edge_o(edge_s)
  );

  ewc_interval_counter #(.W(LIM_W)) u_cnt (
    .clk(clk), .rst(rst), .run(cnt_run), .restart(cnt_restart),
    .tick(tick), .cnt(cnt)
  );

  ewc_ctrl #(
    .LIM_W(LIM_W), .SU_W(SU_W), .NEED_W(NEED_W), .LO_FLOOR(LO_FLOOR)
  ) u_ctrl (
    .clk(clk), .rst(rst), .enable(enable), .tick(tick), .edge_i(edge_s),
    .cnt(cnt), .lim_lo(lim_lo), .lim_hi(lim_hi), .startup_len(startup_len),
    .pass_need(pass_need), .state_o(state_o), .pass_pulse(pass_pulse),
    .fail_pulse(fail_pulse), .cnt_run(cnt_run), .cnt_restart(cnt_restart)
  );
endmodule

// File: tb/edge_window_checker_bench.sv
module edge_window_checker_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       enable = 1'b0;
  logic       demod = 1'b0;
  logic       tick;
  logic [5:0] lim_lo = 6'd14;
  logic [5:0] lim_hi = 6'd24;
  logic [7:0] su_len = 8'd4;
  logic [3:0] need = 4'd3;
  logic [1:0] state_o;
  logic       pass_pulse, fail_pulse;

  int errors = 0, checks = 0;
  int n_pass = 0, n_fail = 0;
  int tick_every = 1;
  logic ph = 1'b0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  always @(negedge clk) ph <= ~ph;
  assign tick = (tick_every == 1) ? 1'b1 : ph;

  always @(negedge clk) begin
    if (pass_pulse) n_pass++;
    if (fail_pulse) n_fail++;
  end

  edge_window_checker u_edge_window_checker (
    .clk(clk), .rst(rst), .enable(enable), .tick(tick), .demod_in(demod),
    .lim_lo(lim_lo), .lim_hi(lim_hi), .startup_len(su_len), .pass_need(need),
    .state_o(state_o), .pass_pulse(pass_pulse), .fail_pulse(fail_pulse)
  );

  // lo, hi, need, spacing(cycles), intervals, exp_pass, exp_fail, exp_state
  localparam int NV = 11;
  localparam int VEC [NV][8] = '{
    '{14, 24, 3, 14, 3, 1, 0, 3},   // R7 lower bound, alternating polarities R4
    '{14, 24, 3, 23, 3, 1, 0, 3},   // R7 upper accepted value
    '{14, 24, 3, 13, 3, 0, 1, 0},   // R8 one short
    '{14, 24, 3, 24, 3, 0, 1, 0},   // R9 edge at exactly hi
    '{14, 24, 2, 40, 1, 0, 1, 0},   // R9 timeout with no edge
    '{ 4, 24, 2, 10, 2, 1, 0, 3},   // R10 clamp accepts 10
    '{ 4, 24, 2,  9, 2, 0, 1, 0},   // R10 clamp rejects 9
    '{20, 63, 2, 62, 2, 1, 0, 3},   // R7 widest window
    '{14, 24, 4, 16, 3, 0, 1, 0},   // R11 too few, then R9 timeout
    '{14, 24, 0, 15, 1, 1, 0, 3},   // R11 need 0 as 1
    '{14, 24, 2, 17, 5, 1, 0, 3}    // R11 extra edges in receive ignored
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_state(input int s, input string tag);
    int k = 0;
    while (state_o != 2'(s) && k < 2000) begin
      @(negedge clk);
      k++;
    end
    check(state_o == 2'(s), tag, state_o, s);
  endtask

  task automatic start(input int lo, input int hi, input int nd, input int su);
    @(negedge clk);
    enable = 1'b0;
    cycles(3);
    lim_lo = 6'(lo); lim_hi = 6'(hi); need = 4'(nd); su_len = 8'(su);
    n_pass = 0; n_fail = 0;
    enable = 1'b1;
  endtask

  task automatic run_train(input int sp, input int nint);
    demod = ~demod;                    // arming edge, R6
    for (int j = 0; j < nint; j++) begin
      cycles(sp);
      demod = ~demod;
    end
    cycles(90);
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    cycles(3);
    check(state_o == 2'd0, "R1 reset state", state_o, 0);
    check(!pass_pulse && !fail_pulse, "R1 reset pulses", {pass_pulse, fail_pulse}, 0);
    @(negedge clk) rst = 1'b0;
    cycles(2);

    for (int v = 0; v < NV; v++) begin
      start(VEC[v][0], VEC[v][1], VEC[v][2], 4);
      wait_state(2, "R2 reach check");
      run_train(VEC[v][3], VEC[v][4]);
      check(n_pass == VEC[v][5], $sformatf("R7/R11 vec%0d pass count", v), n_pass, VEC[v][5]);
      check(n_fail == VEC[v][6], $sformatf("R8/R9 vec%0d fail count", v), n_fail, VEC[v][6]);
      check(state_o == 2'(VEC[v][7]), $sformatf("R8/R11 vec%0d state", v), state_o, VEC[v][7]);
    end

    // R2: exact start-up length and input ignored during start-up
    start(14, 24, 3, 20);
    for (int i = 0; i < 19; i++) begin
      @(negedge clk);
      if (i < 14) demod = ~demod;
      if (i == 18) check(state_o == 2'd1, "R2 still starting", state_o, 1);
    end
    @(negedge clk);
    check(state_o == 2'd1, "R2 start-up last cycle", state_o, 1);
    @(negedge clk);
    check(state_o == 2'd2, "R2 enters check after startup_len", state_o, 2);
    check(n_fail == 0 && n_pass == 0, "R2 start-up ignores input", n_fail + n_pass, 0);

    // R12: timeout fail, then stays asleep with enable held high
    cycles(60);
    check(n_fail == 1, "R9 idle timeout", n_fail, 1);
    cycles(50);
    check(state_o == 2'd0, "R12 stays asleep", state_o, 0);

    // R3: enable drop during check
    start(14, 24, 3, 4);
    wait_state(2, "R3 reach check");
    enable = 1'b0;
    cycles(2);
    check(state_o == 2'd0, "R3 enable low forces sleep", state_o, 0);
    check(n_fail == 0 && n_pass == 0, "R3 no pulse on disable", n_fail + n_pass, 0);

    // R5: tick every other cycle, window counted in ticks
    tick_every = 2;
    start(14, 24, 2, 4);
    wait_state(2, "R5 reach check");
    run_train(28, 2);                  // 14 ticks per interval
    check(n_pass == 1 && state_o == 2'd3, "R5 14 ticks accepted", n_pass, 1);
    start(14, 24, 2, 4);
    wait_state(2, "R5 reach check 2");
    run_train(26, 2);                  // 13 ticks per interval
    check(n_fail == 1 && state_o == 2'd0, "R5 13 ticks rejected", n_fail, 1);
    tick_every = 1;

    finished = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule